// File: doc/BRIEF.md
# Pause-Frame Flow Control Unit

This block handles pause-based flow control for a single Ethernet port. On the receive side, a strobe reports that a pause frame has arrived and carries its 16-bit pause value. That value loads a countdown timer. The timer counts down by one on each quantum tick, where one tick is 512 bit times. While the timer is above zero, the block refuses to start any new normal frame. A frame that was already granted keeps its grant until its requester lets go.

On the transmit side, the block watches an occupancy level for the resources the port feeds. When occupancy reaches the high threshold, it requests a pause frame with the largest pause value, which acts as an XOFF. Once XOFF has been sent and occupancy has drained to the low threshold, it requests a pause frame with value zero, which acts as an XON. The gap between the two thresholds gives hysteresis. Pause-frame requests are never blocked by the received pause. Frame encoding and parsing are handled elsewhere.

Top module: `pause_flow_ctrl`

## Requirements
- R1: While the pause count is non-zero, `norm_grant` stays low for a requester not already in a frame. A pause strobe takes effect in the cycle after it is sampled.
- R2: A pause strobe loads the count with `pause_rx_value`. This overwrites any running count, and it takes priority over a tick in the same cycle.
- R3: Each `quanta_tick` without a strobe lowers a non-zero count by one. The count holds at zero, and it does not change without a tick.
- R4: A received pause value of zero ends the pause. `norm_grant` is available in the next cycle.
- R5: Once a frame has been granted (`norm_req` and `norm_grant` both high at a clock edge), `norm_grant` stays high for as long as `norm_req` stays high, even if a pause arrives.
- R6: When no XOFF is outstanding, no request is pending, and `occupancy >= thr_high`, then in the next cycle `fc_req` is high and `fc_value` is 0xFFFF.
- R7: When XOFF has been sent, no request is pending, and `occupancy <= thr_low`, then in the next cycle `fc_req` is high and `fc_value` is 0x0000. An XON is never requested unless an XOFF was sent first.
- R8: With occupancy strictly between the thresholds, no new request is raised. A raised request keeps its value until `fc_ack`, and it drops in the cycle after `fc_ack`.
- R9: Pause-frame requests (`fc_req`, `fc_value`) behave the same whether or not the port is paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pause_rx_valid | input | 1 | One-cycle strobe: a pause frame was received |
| pause_rx_value | input | 16 | Pause time in quanta carried by that frame |
| quanta_tick | input | 1 | One-cycle strobe every 512 bit times |
| norm_req | input | 1 | Normal frame wants to start or is in progress (held for the whole frame) |
| norm_grant | output | 1 | Normal frame may start or continue |
| occupancy | input | OCC_W (8) | Current resource occupancy level |
| thr_high | input | OCC_W (8) | XOFF threshold (at or above) |
| thr_low | input | OCC_W (8) | XON threshold (at or below), below `thr_high` |
| fc_req | output | 1 | Request to send a pause frame |
| fc_value | output | 16 | Pause value for the requested frame (0xFFFF or 0) |
| fc_ack | input | 1 | The requested pause frame was sent |

## Verification
The hardest cases to reach from the ports involve timing coincidences. One is a pause strobe that lands in the middle of a granted frame. Another is a reload that arrives in the same cycle as a tick. A third is occupancy that hovers between the two thresholds while a request is still waiting for its acknowledge. Directed sequences set up each of these on purpose. A long random phase then drives occupancy as a bounded random walk that crosses both thresholds many times, along with sparse pause strobes, frequent ticks, and random acknowledges. Throughout that phase, a bench model of the timer, the frame state and the hysteresis state predicts every output.

// File: rtl/pfc_pkg.sv
// Shared types for the pause-frame flow control unit.
package pfc_pkg;
    // Transmit-side hysteresis state.
    typedef enum logic [1:0] {
        FC_IDLE      = 2'd0,
        FC_SEND_XOFF = 2'd1,
        FC_HOLD      = 2'd2,
        FC_SEND_XON  = 2'd3
    } fc_state_e;
endpackage

// File: rtl/pfc_pause_timer.sv
// Receive-side pause countdown.
// Loads the count from a received pause value. A load overrides a
// coincident tick. Otherwise the count drops by one per quantum tick
// and holds at zero.
// Assumes the strobes are single-cycle and synchronous to clk.
module pfc_pause_timer #(
    parameter int PV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PV_W-1:0] load_value,
    input  logic            tick,
    output logic [PV_W-1:0] count,
    output logic            paused
);
    localparam logic [PV_W-1:0] ONE = PV_W'(1);

    // Count register: reload on strobe, otherwise decrement on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_value;
        end else if (tick && (count != '0)) begin
            count <= count - ONE;
        end
    end

    // The port is paused while the count is non-zero.
    always_comb paused = (count != '0);
endmodule

// File: rtl/pfc_tx_gate.sv
// Normal-frame start gate.
// A new frame may start only when not paused. A frame that has started
// keeps its grant for as long as its request stays high.
// Assumes the requester holds its request for the whole frame.
module pfc_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic paused,
    input  logic req,
    output logic grant,
    output logic in_frame
);
    // Grant: continue a running frame, or start one when not paused.
    always_comb grant = req && (in_frame || !paused);

    // Frame-in-progress flag: set by a granted request, cleared when the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
        end else begin
            in_frame <= req && grant;
        end
    end
endmodule

// File: rtl/pfc_hyst_ctrl.sv
// Transmit-side XOFF/XON request generator with hysteresis.
// Raises an XOFF request (maximum value) at or above the high threshold,
// and an XON request (zero) at or below the low threshold, but only after
// an XOFF was sent. A request is held until acknowledged.
// Assumes thr_low < thr_high.
module pfc_hyst_ctrl #(
    parameter int OCC_W = 8,
    parameter int PV_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] occupancy,
    input  logic [OCC_W-1:0] thr_high,
    input  logic [OCC_W-1:0] thr_low,
    input  logic             ack,
    output logic             req,
    output logic [PV_W-1:0]  value,
    output logic             xoff_on
);
    import pfc_pkg::*;

    localparam logic [PV_W-1:0] PAUSE_MAX = '1;

    fc_state_e state, state_nx;

    // Next-state logic of the hysteresis machine.
    always_comb begin
        state_nx = state;
        unique case (state)
            FC_IDLE:      if (occupancy >= thr_high) state_nx = FC_SEND_XOFF;
            FC_SEND_XOFF: if (ack)                   state_nx = FC_HOLD;
            FC_HOLD:      if (occupancy <= thr_low)  state_nx = FC_SEND_XON;
            FC_SEND_XON:  if (ack)                   state_nx = FC_IDLE;
            default:                                 state_nx = FC_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FC_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Request outputs decoded from the state.
    always_comb begin
        req     = (state == FC_SEND_XOFF) || (state == FC_SEND_XON);
        value   = (state == FC_SEND_XOFF) ? PAUSE_MAX : '0;
        xoff_on = (state == FC_HOLD) || (state == FC_SEND_XON);
    end
endmodule

// File: rtl/pause_flow_ctrl.sv
// Pause-frame flow control unit for one port.
// Receive side: a pause timer gates the start of normal frames.
// Transmit side: a hysteresis machine requests XOFF and XON pause frames.
// The two sides are independent, so pause-frame requests are never gated
// by a received pause.
module pause_flow_ctrl #(
    parameter int OCC_W = 8,
    parameter int PV_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pause_rx_valid,
    input  logic [PV_W-1:0]  pause_rx_value,
    input  logic             quanta_tick,
    input  logic             norm_req,
    output logic             norm_grant,
    input  logic [OCC_W-1:0] occupancy,
    input  logic [OCC_W-1:0] thr_high,
    input  logic [OCC_W-1:0] thr_low,
    output logic             fc_req,
    output logic [PV_W-1:0]  fc_value,
    input  logic             fc_ack
);
    logic [PV_W-1:0] pause_cnt;
    logic            paused;
    logic            in_frame;
    logic            xoff_on;

    pfc_pause_timer #(.PV_W(PV_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pause_rx_valid),
        .load_value (pause_rx_value),
        .tick       (quanta_tick),
        .count      (pause_cnt),
        .paused     (paused)
    );

    pfc_tx_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .paused   (paused),
        .req      (norm_req),
        .grant    (norm_grant),
        .in_frame (in_frame)
    );

    pfc_hyst_ctrl #(.OCC_W(OCC_W), .PV_W(PV_W)) u_hyst (
        .clk       (clk),
        .rst_n     (rst_n),
        .occupancy (occupancy),
        .thr_high  (thr_high),
        .thr_low   (thr_low),
        .ack       (fc_ack),
        .req       (fc_req),
        .value     (fc_value),
        .xoff_on   (xoff_on)
    );
endmodule

// File: rtl/pfc_checker.sv
// Property checker for pause_flow_ctrl, attached by bind.
// Observes the ports and the internal count, frame and XOFF-outstanding state.
module pfc_checker #(
    parameter int OCC_W = 8,
    parameter int PV_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pause_rx_valid,
    input logic [PV_W-1:0]  pause_rx_value,
    input logic             quanta_tick,
    input logic             norm_req,
    input logic             norm_grant,
    input logic [OCC_W-1:0] occupancy,
    input logic [OCC_W-1:0] thr_high,
    input logic [OCC_W-1:0] thr_low,
    input logic             fc_req,
    input logic [PV_W-1:0]  fc_value,
    input logic             fc_ack,
    input logic [PV_W-1:0]  pause_cnt,
    input logic             in_frame,
    input logic             xoff_on
);
    localparam logic [PV_W-1:0] PMAX = '1;
    localparam logic [PV_W-1:0] ONE  = PV_W'(1);

    AST_NO_START_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_cnt != '0) && !in_frame |-> !norm_grant); // R1
    AST_PAUSE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pause_rx_valid |=> pause_cnt == $past(pause_rx_value)); // R2
    AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_rx_valid && quanta_tick && (pause_cnt != '0) |=> pause_cnt == $past(pause_cnt) - ONE); // R3
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_rx_valid && !quanta_tick |=> $stable(pause_cnt)); // R3
    AST_ZERO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pause_rx_valid && (pause_rx_value == '0) |=> (norm_grant == norm_req)); // R4
    AST_FRAME_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        norm_req && norm_grant |=> !norm_req || norm_grant); // R5
    AST_XOFF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_req && !xoff_on && (occupancy >= thr_high) |=> fc_req && (fc_value == PMAX)); // R6
    AST_XON_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_req && xoff_on && (occupancy <= thr_low) |=> fc_req && (fc_value == '0)); // R7
    AST_XON_AFTER_XOFF: assert property (@(posedge clk) disable iff (!rst_n)
        fc_req && (fc_value == '0) |-> xoff_on); // R7
    AST_NO_REQ_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_req && (occupancy > thr_low) && (occupancy < thr_high) |=> !fc_req); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fc_req && !fc_ack |=> fc_req && $stable(fc_value)); // R8
    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        fc_req && fc_ack |=> !fc_req); // R8
endmodule

bind pause_flow_ctrl pfc_checker #(.OCC_W(OCC_W), .PV_W(PV_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pause_rx_valid (pause_rx_valid),
    .pause_rx_value (pause_rx_value),
    .quanta_tick    (quanta_tick),
    .norm_req       (norm_req),
    .norm_grant     (norm_grant),
    .occupancy      (occupancy),
    .thr_high       (thr_high),
    .thr_low        (thr_low),
    .fc_req         (fc_req),
    .fc_value       (fc_value),
    .fc_ack         (fc_ack),
    .pause_cnt      (pause_cnt),
    .in_frame       (in_frame),
    .xoff_on        (xoff_on)
);

// File: tb/tb_pause_flow_ctrl.sv
`timescale 1ns/100ps
module tb_pause_flow_ctrl;
    localparam int OCC_W = 8;
    localparam int PV_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pause_rx_valid = 1'b0;
    logic [PV_W-1:0]  pause_rx_value = '0;
    logic             quanta_tick = 1'b0;
    logic             norm_req = 1'b0;
    logic             norm_grant;
    logic [OCC_W-1:0] occupancy = '0;
    logic [OCC_W-1:0] thr_high = 8'd180;
    logic [OCC_W-1:0] thr_low = 8'd60;
    logic             fc_req;
    logic [PV_W-1:0]  fc_value;
    logic             fc_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state, derived from the requirements.
    int unsigned m_cnt = 0;
    bit          m_inframe = 1'b0;
    int          m_state = 0; // 0 idle, 1 XOFF pending, 2 XOFF sent, 3 XON pending

    always #2 clk = ~clk; // 250 MHz

    pause_flow_ctrl #(.OCC_W(OCC_W), .PV_W(PV_W)) dut (.*);

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_grant();
        return norm_req && (m_inframe || m_cnt == 0);
    endfunction
    function automatic bit exp_fcreq();
        return (m_state == 1) || (m_state == 3);
    endfunction
    function automatic int unsigned exp_fcval();
        return (m_state == 1) ? 32'hFFFF : 32'h0;
    endfunction

    // One cycle: inputs already driven at negedge; compare, then advance the model.
    task automatic cyc();
        bit g;
        #0.5;
        g = exp_grant();
        chk((m_inframe || m_cnt == 0) ? "R5 grant" : "R1 grant", norm_grant, g);
        chk((m_state == 3 || m_state == 2) ? "R7 fc_req" : "R6 fc_req", fc_req, exp_fcreq());
        if (exp_fcreq()) chk(m_state == 1 ? "R6 fc_value" : "R7 fc_value", fc_value, exp_fcval());
        @(posedge clk);
        m_inframe = norm_req && g;
        if (pause_rx_valid) m_cnt = pause_rx_value;
        else if (quanta_tick && m_cnt != 0) m_cnt = m_cnt - 1;
        case (m_state)
            0: if (occupancy >= thr_high) m_state = 1;
            1: if (fc_ack) m_state = 2;
            2: if (occupancy <= thr_low) m_state = 3;
            default: if (fc_ack) m_state = 0;
        endcase
        @(negedge clk);
        pause_rx_valid = 1'b0;
        quanta_tick = 1'b0;
        fc_ack = 1'b0;
    endtask

    task automatic pause(input int unsigned v);
        pause_rx_valid = 1'b1;
        pause_rx_value = PV_W'(v);
        cyc();
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int occ;
        void'($urandom(32'd4242));
        occupancy = 8'd100;
        repeat (3) @(negedge clk);
        norm_req = 1'b1;
        #0.3;
        chk("R1 reset grant", norm_grant, 1);
        chk("R6 reset fc_req", fc_req, 0);
        rst_n = 1'b1;
        cyc();
        norm_req = 1'b0;
        cyc();

        // R2: reload overwrites a running count; reload beats a coincident tick.
        pause(50);
        repeat (3) begin quanta_tick = 1'b1; cyc(); end
        pause_rx_valid = 1'b1; pause_rx_value = 16'd5; quanta_tick = 1'b1; cyc();
        for (int i = 0; i < 4; i++) begin quanta_tick = 1'b1; cyc(); end
        norm_req = 1'b1; #0.3;
        chk("R2 still paused after reload", norm_grant, 0);
        quanta_tick = 1'b1; cyc();
        #0.3;
        chk("R3 released after 5 ticks", norm_grant, 1);
        norm_req = 1'b0;
        // R3: no tick, no change.
        pause(2);
        repeat (10) cyc();
        norm_req = 1'b1; #0.3;
        chk("R3 count holds without tick", norm_grant, 0);
        norm_req = 1'b0;
        // R4: zero releases at once.
        pause(300);
        pause(0);
        norm_req = 1'b1; #0.3;
        chk("R4 zero pause releases", norm_grant, 1);
        // R5: frame in progress survives a pause.
        cyc();
        pause(20);
        #0.3;
        chk("R5 frame continues", norm_grant, 1);
        norm_req = 1'b0; cyc();
        norm_req = 1'b1; #0.3;
        chk("R1 new frame blocked", norm_grant, 0);
        // R9: XOFF while paused.
        occupancy = 8'd200; cyc();
        #0.3;
        chk("R9 fc_req while paused", fc_req, 1);
        chk("R9 fc_value while paused", fc_value, 16'hFFFF);
        // R8: held without ack, then no XON between thresholds.
        repeat (4) cyc();
        #0.3;
        chk("R8 request held", fc_req, 1);
        fc_ack = 1'b1; cyc();
        occupancy = 8'd100;
        repeat (5) cyc();
        #0.3;
        chk("R8 no request between thresholds", fc_req, 0);
        occupancy = 8'd60; cyc();
        #0.3;
        chk("R7 XON at low threshold", fc_req, 1);
        chk("R7 XON value", fc_value, 0);
        fc_ack = 1'b1; cyc();
        pause(0);
        norm_req = 1'b0; cyc();

        // Random phase.
        occ = 100;
        for (int n = 0; n < 6000; n++) begin
            occ = occ + int'($urandom_range(0, 16)) - 8;
            if (occ < 0) occ = 0;
            if (occ > 255) occ = 255;
            occupancy = OCC_W'(occ);
            quanta_tick = ($urandom_range(0, 2) == 0);
            fc_ack = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 39) == 0) begin
                pause_rx_valid = 1'b1;
                pause_rx_value = ($urandom_range(0, 4) == 0) ? 16'd0 : PV_W'($urandom_range(1, 40));
            end
            if (norm_req) norm_req = ($urandom_range(0, 7) != 0);
            else norm_req = ($urandom_range(0, 2) == 0);
            cyc();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule